// File: doc/BRIEF.md
# Speculative Loop Recovery Controller

This block runs a loop that carries a main value `x` and a side value `y` from one iteration to the next. The next `x` normally comes from a one-cycle fast step. A multi-cycle slow step replaces it when a condition on the current `x` holds. The condition result arrives several cycles after the value it tests, so the controller does not wait for it. Every cycle it assumes the fast step and launches the next iteration on that guess. When the delayed condition confirms the guess, the value is committed. When the condition shows the guess was wrong, the controller waits for the slow result, replaces the wrong value with it, restores the side value from a short history, and restarts the pipeline.

The fast, slow and condition functions are small delay-line stubs whose latencies are elaboration parameters. `LAT_C` is the condition latency and `LAT_S` is the slow-path latency; the fast and side steps take one cycle. These two latencies set the length of the start-up phase and of the recovery phase. The environment gives a starting pair and a condition mask, then pulses `start`. It reads the ordered stream of committed pairs, and ends the run with `stop`.

Top module: `spec_recovery_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `commit_o`, `rollback_o` and `sel_o` are all 0.
- R2: A `start` sampled in idle with `stop` low loads `init_x`/`init_y` as the iteration-0 pair, and `state_o` becomes 1 (fill) at that edge. If the first iteration takes the fast step, its commit appears `LAT_C` edges after the edge that sampled `start`.
- R3: When the condition is false for the last committed pair (x, y), the next commit has `sel_o`=1 and `rollback_o`=0, with `commit_x_o` = (x+1) mod 2^W and `commit_y_o` = (y+x) mod 2^W.
- R4: A value x takes the slow step when (x AND `slow_mask`) equals `slow_mask`. The slow result is (2x+3) mod 2^W, and that value is the next committed x.
- R5: When a wrong guess is detected in run, `state_o` shows 3 (stall) for exactly `LAT_S`−`LAT_C`−1 cycles and then 4 (rollback) for one cycle. The commit produced there has `sel_o`=0 and `rollback_o`=1.
- R6: In a rollback commit, `commit_y_o` equals (y+x) mod 2^W of the last committed pair. The controller restores it from a history that is `LAT_S`−1 cycles deep, and the squashed iterations leave no trace in it.
- R7: After the rollback cycle, fill lasts `LAT_C`−1 cycles, and condition results seen outside run are ignored. Decisions are spaced 1 cycle after a fast iteration and `LAT_S` cycles after a slow one. A slow iteration's commit appears `LAT_S`−`LAT_C` edges after its decision point. No commit appears at any other edge.
- R8: The committed stream equals the recurrence of R3/R4 from the loaded pair, in order, with no gap and no repeat.
- R9: A `stop` sampled in any state puts `state_o` at 0 on that edge with no commit. The block then stays idle, with no commit, until the next `start`.
- R10: A fast commit appears together with `state_o`=2 (run), a rollback commit appears together with `state_o`=1 (fill), and `state_o` never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a loop run from idle |
| stop | input | 1 | Abandon the run and return to idle |
| init_x | input | W | Starting main value |
| init_y | input | W | Starting side value |
| slow_mask | input | W | Bits that must all be set in x for the slow step |
| commit_o | output | 1 | A confirmed pair is on the commit outputs |
| rollback_o | output | 1 | This commit came from recovery |
| sel_o | output | 1 | 1: pair came from the fast guess; 0: from the slow path |
| state_o | output | 3 | Controller phase: 0 idle, 1 fill, 2 run, 3 stall, 4 rollback |
| commit_x_o | output | W | Committed main value |
| commit_y_o | output | W | Committed side value |

## Verification
A wrong phase length or a stale condition taken as valid moves the next commit to the wrong edge, so the bench checks at every edge whether a commit is expected. The error is seen within one `LAT_S` window. A wrong restore distance for the side value, or a lost slow result, changes the value in the next rollback commit. Because the bench feeds each committed pair into the next expected value, any corruption also makes every later commit in that run fail. Masks of all zeros force recovery on every iteration, and mixed masks give back-to-back wrong guesses right after fill.

// File: rtl/spec_rc_pkg.sv
`timescale 1ns/1ps
package spec_rc_pkg;
  // Phase codes are visible on state_o; values are fixed by the port contract.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_RUN   = 3'd2,
    ST_STALL = 3'd3,
    ST_ROLLB = 3'd4
  } ctl_state_t;
endpackage

// File: rtl/spec_dly_line.sv
`timescale 1ns/1ps
// Plain shift register with no reset, so it can map onto shift-register storage.
module spec_dly_line #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    stage[0] <= d;
    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
  end

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/spec_rc_datapath.sv
`timescale 1ns/1ps
// Speculative datapath: live registers, function stubs and value histories.
module spec_rc_datapath #(
  parameter int W     = 16,
  parameter int LAT_C = 2,
  parameter int LAT_S = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         restore,
  input  logic [W-1:0] init_x,
  input  logic [W-1:0] init_y,
  input  logic [W-1:0] slow_mask,
  output logic         ctrl,
  output logic [W-1:0] slow_x,
  output logic [W-1:0] cmt_x,
  output logic [W-1:0] cmt_y,
  output logic [W-1:0] hist_y
);
  localparam int ALIGN_D = LAT_C - 1;  // commit distance
  localparam int HIST_D  = LAT_S - 1;  // rollback distance of the side value
  localparam int SLOW_D  = LAT_S - 1;
  localparam int COND_D  = LAT_C - 1;

  function automatic logic [W-1:0] step_fast(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  function automatic logic [W-1:0] step_slow(input logic [W-1:0] v);
    return (v << 1) + W'(3);
  endfunction

  function automatic logic [W-1:0] step_side(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic needs_slow(input logic [W-1:0] v, input logic [W-1:0] m);
    return (v & m) == m;
  endfunction

  logic [W-1:0] sx_q, sy_q, sx_d, sy_d;
  logic [0:0]   cond_now, cond_late;

  always_comb begin
    if (load) begin
      sx_d = init_x;
      sy_d = init_y;
    end else if (restore) begin
      sx_d = slow_x;
      sy_d = hist_y;
    end else begin
      sx_d = step_fast(sx_q);
      sy_d = step_side(sx_q, sy_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sx_q <= '0;
      sy_q <= '0;
    end else begin
      sx_q <= sx_d;
      sy_q <= sy_d;
    end
  end

  assign cond_now = needs_slow(sx_q, slow_mask);
  assign ctrl     = cond_late[0];

  spec_dly_line #(.W(1), .DEPTH(COND_D)) cond_line_i (
    .clk(clk), .d(cond_now), .q(cond_late));

  spec_dly_line #(.W(W), .DEPTH(SLOW_D)) slow_line_i (
    .clk(clk), .d(step_slow(sx_q)), .q(slow_x));

  spec_dly_line #(.W(W), .DEPTH(ALIGN_D)) xalign_i (
    .clk(clk), .d(sx_d), .q(cmt_x));

  spec_dly_line #(.W(W), .DEPTH(ALIGN_D)) yalign_i (
    .clk(clk), .d(sy_d), .q(cmt_y));

  spec_dly_line #(.W(W), .DEPTH(HIST_D)) yhist_i (
    .clk(clk), .d(sy_d), .q(hist_y));
endmodule

// File: rtl/spec_rc_fsm.sv
`timescale 1ns/1ps
// Phase controller: speculate in run, time recovery with one down-counter.
module spec_rc_fsm
  import spec_rc_pkg::*;
#(
  parameter int LAT_C = 2,
  parameter int LAT_S = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop,
  input  logic       ctrl,
  output ctl_state_t state_q,
  output logic       load,
  output logic       commit,
  output logic       restore,
  output logic       sel
);
  localparam int FILL_CYC  = LAT_C - 1;
  localparam int STALL_CYC = LAT_S - LAT_C - 1;
  localparam int CNT_W     = $clog2(LAT_S + 1);
  localparam logic [CNT_W-1:0] FILL_LD  = CNT_W'(FILL_CYC - 1);
  localparam logic [CNT_W-1:0] STALL_LD = CNT_W'((STALL_CYC > 0) ? STALL_CYC - 1 : 0);

  ctl_state_t       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    commit  = 1'b0;
    restore = 1'b0;
    sel     = 1'b0;
    if (stop) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_d = ST_FILL;
          cnt_d   = FILL_LD;
          load    = 1'b1;
        end
        ST_FILL: begin
          if (cnt_q == '0) state_d = ST_RUN;
          else             cnt_d   = cnt_q - 1'b1;
        end
        ST_RUN: begin
          if (ctrl) begin
            if (STALL_CYC == 0) begin
              state_d = ST_ROLLB;
            end else begin
              state_d = ST_STALL;
              cnt_d   = STALL_LD;
            end
          end else begin
            commit = 1'b1;
            sel    = 1'b1;
          end
        end
        ST_STALL: begin
          if (cnt_q == '0) state_d = ST_ROLLB;
          else             cnt_d   = cnt_q - 1'b1;
        end
        ST_ROLLB: begin
          commit  = 1'b1;
          restore = 1'b1;
          state_d = ST_FILL;
          cnt_d   = FILL_LD;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/spec_recovery_ctrl.sv
`timescale 1ns/1ps
module spec_recovery_ctrl
  import spec_rc_pkg::*;
#(
  parameter int W     = 16,
  parameter int LAT_C = 2,
  parameter int LAT_S = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         stop,
  input  logic [W-1:0] init_x,
  input  logic [W-1:0] init_y,
  input  logic [W-1:0] slow_mask,
  output logic         commit_o,
  output logic         rollback_o,
  output logic         sel_o,
  output logic [2:0]   state_o,
  output logic [W-1:0] commit_x_o,
  output logic [W-1:0] commit_y_o
);
  ctl_state_t   fsm_state;
  logic         load, commit, restore, sel, ctrl;
  logic [W-1:0] slow_x, cmt_x, cmt_y, hist_y;

  spec_rc_fsm #(.LAT_C(LAT_C), .LAT_S(LAT_S)) fsm_i (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .ctrl(ctrl),
    .state_q(fsm_state), .load(load), .commit(commit),
    .restore(restore), .sel(sel));

  spec_rc_datapath #(.W(W), .LAT_C(LAT_C), .LAT_S(LAT_S)) dp_i (
    .clk(clk), .rst(rst), .load(load), .restore(restore),
    .init_x(init_x), .init_y(init_y), .slow_mask(slow_mask),
    .ctrl(ctrl), .slow_x(slow_x), .cmt_x(cmt_x), .cmt_y(cmt_y),
    .hist_y(hist_y));

  assign state_o = fsm_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_o   <= 1'b0;
      rollback_o <= 1'b0;
      sel_o      <= 1'b0;
      commit_x_o <= '0;
      commit_y_o <= '0;
    end else begin
      commit_o   <= commit;
      rollback_o <= restore & commit;
      sel_o      <= sel;
      commit_x_o <= sel ? cmt_x : slow_x;
      commit_y_o <= sel ? cmt_y : hist_y;
    end
  end
endmodule

// File: rtl/spec_rc_chk.sv
`timescale 1ns/1ps
module spec_rc_chk #(
  parameter int LAT_C = 2,
  parameter int LAT_S = 5
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       stop,
  input logic       commit_o,
  input logic       rollback_o,
  input logic       sel_o,
  input logic [2:0] state_o
);
  localparam int STALL_CYC = LAT_S - LAT_C - 1;
  localparam int CW        = $clog2(LAT_S + 2);
  localparam logic [CW-1:0] STALL_LIM = CW'(STALL_CYC);
  localparam logic [2:0] P_IDLE = 3'd0, P_FILL = 3'd1, P_RUN = 3'd2,
                         P_STALL = 3'd3, P_ROLLB = 3'd4;

  logic [CW-1:0] stall_run;
  always_ff @(posedge clk) begin
    if (rst)                     stall_run <= '0;
    else if (state_o == P_STALL) stall_run <= stall_run + 1'b1;
    else                         stall_run <= '0;
  end

  assert_rollback_marks_R5: assert property (@(posedge clk) disable iff (rst)
    rollback_o |-> (commit_o && !sel_o)) else $error("rollback flag without slow commit");

  assert_rollb_commits_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == P_ROLLB && !stop) |=> rollback_o) else $error("rollback cycle produced no commit");

  assert_stall_len_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == P_STALL) |-> (stall_run < STALL_LIM)) else $error("stall phase too long");

  assert_fill_after_rb_R7: assert property (@(posedge clk) disable iff (rst)
    rollback_o |-> (state_o == P_FILL)) else $error("no fill after rollback");

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> (state_o == P_IDLE && !commit_o)) else $error("stop not honoured");

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o == P_IDLE && !start) |=> (state_o == P_IDLE)) else $error("left idle without start");

  assert_fast_in_run_R10: assert property (@(posedge clk) disable iff (rst)
    (commit_o && sel_o) |-> (state_o == P_RUN)) else $error("fast commit outside run");

  assert_state_legal_R10: assert property (@(posedge clk) disable iff (rst)
    state_o <= P_ROLLB) else $error("illegal phase code");
endmodule

bind spec_recovery_ctrl spec_rc_chk #(.LAT_C(LAT_C), .LAT_S(LAT_S)) chk_i (
  .clk(clk), .rst(rst), .start(start), .stop(stop), .commit_o(commit_o),
  .rollback_o(rollback_o), .sel_o(sel_o), .state_o(state_o));

// File: tb/spec_recovery_ctrl_tb_top.sv
`timescale 1ns/1ps
module spec_recovery_ctrl_tb_top;
  localparam int W     = 16;
  localparam int LAT_C = 2;
  localparam int LAT_S = 5;
  localparam int STALL_CYC = LAT_S - LAT_C - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0, stop = 1'b0;
  logic [W-1:0] init_x = '0, init_y = '0, slow_mask = '0;
  logic         commit_o, rollback_o, sel_o;
  logic [2:0]   state_o;
  logic [W-1:0] commit_x_o, commit_y_o;

  spec_recovery_ctrl #(.W(W), .LAT_C(LAT_C), .LAT_S(LAT_S)) dut_i (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .init_x(init_x),
    .init_y(init_y), .slow_mask(slow_mask), .commit_o(commit_o),
    .rollback_o(rollback_o), .sel_o(sel_o), .state_o(state_o),
    .commit_x_o(commit_x_o), .commit_y_o(commit_y_o));

  always #10 clk = ~clk;

  int edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  int checks = 0, errors = 0;
  bit running = 1'b0, first_c = 1'b0;
  logic [W-1:0] xr, yr, mr;
  int dec_edge, exp_edge, stall_seen;

  function automatic logic [W-1:0] ref_fast(input logic [W-1:0] v); return v + 16'd1; endfunction
  function automatic logic [W-1:0] ref_slow(input logic [W-1:0] v); return {v[W-2:0], 1'b0} + 16'd3; endfunction
  function automatic logic ref_cond(input logic [W-1:0] v, input logic [W-1:0] m); return (v & m) == m; endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at edge %0d", req, what, act, exp, edge_cnt);
    end
  endtask

  task automatic monitor();
    logic slow;
    logic [W-1:0] nx, ny;
    if (!running) return;
    if (state_o == 3'd3) stall_seen++;
    if (edge_cnt == exp_edge) begin
      slow = ref_cond(xr, mr);
      nx = slow ? ref_slow(xr) : ref_fast(xr);
      ny = yr + xr;
      chk(commit_o == 1'b1, first_c ? "R2" : "R7", "commit at scheduled edge", commit_o, 1);
      chk(commit_x_o == nx, slow ? "R4" : "R3", "committed x", commit_x_o, nx);
      chk(commit_y_o == ny, slow ? "R6" : "R3", "committed y", commit_y_o, ny);
      chk(sel_o == !slow, slow ? "R5" : "R3", "select", sel_o, !slow);
      chk(rollback_o == slow, slow ? "R5" : "R3", "rollback flag", rollback_o, slow);
      chk(state_o == (slow ? 3'd1 : 3'd2), "R10", "phase at commit", state_o, slow ? 1 : 2);
      if (slow) chk(stall_seen == STALL_CYC, "R5", "stall cycles", stall_seen, STALL_CYC);
      stall_seen = 0;
      first_c = 1'b0;
      xr = nx;
      yr = ny;
      dec_edge = slow ? dec_edge + LAT_S : dec_edge + 1;
      exp_edge = ref_cond(xr, mr) ? dec_edge + LAT_S - LAT_C : dec_edge;
    end else begin
      chk(commit_o == 1'b0, "R8", "no commit off schedule", commit_o, 0);
    end
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
  endtask

  task automatic run_ep(input logic [W-1:0] x0, input logic [W-1:0] y0,
                        input logic [W-1:0] m, input int ncyc);
    step();
    start = 1'b1; init_x = x0; init_y = y0; slow_mask = m;
    xr = x0; yr = y0; mr = m;
    dec_edge = edge_cnt + 1 + LAT_C;
    exp_edge = ref_cond(x0, m) ? dec_edge + LAT_S - LAT_C : dec_edge;
    stall_seen = 0; first_c = 1'b1; running = 1'b1;
    step();
    start = 1'b0;
    chk(state_o == 3'd1, "R2", "fill after start", state_o, 1);
    repeat (ncyc) step();
    stop = 1'b1;
    running = 1'b0;
    step();
    stop = 1'b0;
    chk(state_o == 3'd0, "R9", "idle after stop", state_o, 0);
    chk(commit_o == 1'b0, "R9", "no commit on stop", commit_o, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(state_o == 3'd0 && commit_o == 1'b0, "R9", "stays idle", {state_o, commit_o}, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(state_o == 3'd0, "R1", "reset phase", state_o, 0);
    chk(commit_o == 1'b0 && rollback_o == 1'b0 && sel_o == 1'b0, "R1", "reset flags",
        {commit_o, rollback_o, sel_o}, 0);
    run_ep(16'h0010, 16'h0001, 16'hFFFF, 40);  // R3: all fast
    run_ep(16'h0005, 16'h0009, 16'h0000, 40);  // R5 R7: recovery every iteration
    run_ep(16'h0000, 16'h0000, 16'h0003, 60);  // R4: mixed
    run_ep(16'hFFFD, 16'hFFF0, 16'hFFFF, 12);  // R4: wrap through all-ones
    run_ep(16'h0001, 16'h0002, 16'h0001, 30);  // R6: slow result stays slow
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] m;
      m = (i % 3 == 0) ? W'(16'h1 << ($urandom % 4)) : W'($urandom & $urandom & 16'h00FF);
      run_ep(W'($urandom), W'($urandom), m, 30 + int'($urandom % 60));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule